// File: doc/BRIEF.md
# Latency-Tolerant Packet Deframer

The block sits behind a FIFO that holds a stream of 32-bit words and cuts that stream into packets. The first word of each packet is a header. Its upper byte names a destination, and its lower 24 bits give the packet's total length in words, counting the header. The destination is looked up in a small table of known destinations, which is loaded through a simple write port. The payload words that follow then leave on an output stream. Each payload word carries the index of the matching table entry, and the final word of the packet is flagged.

The FIFO returns data a fixed number of cycles after a read strobe, and its flags may lag. The block therefore paces its reads with the FIFO's empty and almost-empty flags. It builds a data-valid signal by delaying each strobe through a pipeline that matches the FIFO's read latency. Packet boundaries are found by counting only the words that actually arrive, so a pause of any length inside a packet does not disturb framing. A header with an unknown destination, or one with an impossible length, raises an error pulse. In that case the block skips the words that header declares and takes the word after them as the next header.

Top module: `pkt_deframer`

## Requirements
- R1: After reset, `fifo_rd`, `out_valid`, `out_last` and `hdr_err` are low, and the block waits for a header.
- R2: `fifo_rd` is never high in a cycle where `fifo_empty` is high.
- R3: While `fifo_almost_empty` is high, no new strobe is issued until the word from the previous strobe has been returned, so at most one read is outstanding.
- R4: While `fifo_empty` and `fifo_almost_empty` are both low, `fifo_rd` is high in every cycle.
- R5: A word is consumed only when it is returned, `RD_LAT` cycles after its strobe. Each payload word appears on `out_data` one cycle after it is returned, with no loss, duplication or reordering, whatever the gaps in the incoming stream.
- R6: A header is laid out as destination in bits [31:24] and total length in words in bits [23:0]. A header with length L >= 2 whose destination matches a valid table entry produces exactly L-1 output words. `out_idx` equals the matching entry's index, and `out_last` is high only with the final word.
- R7: When several valid entries hold the same destination, the lowest index wins.
- R8: A header with length >= 2 and no matching valid entry raises `hdr_err` for one cycle. The next L-1 words are discarded without any `out_valid`, and the word after them is treated as a header.
- R9: A header with length 0 or 1 raises `hdr_err` for one cycle, discards nothing, and the very next word is treated as a header.
- R10: A table write with `tbl_we` high stores `tbl_dest` and `tbl_valid` into entry `tbl_addr`. An entry written with `tbl_valid` low no longer matches, so its destination is handled as unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | FIFO holds no words |
| fifo_almost_empty | input | 1 | FIFO occupancy at or below its threshold (8) |
| fifo_rd | output | 1 | FIFO read strobe |
| fifo_data | input | 32 | FIFO read data, valid RD_LAT cycles after a strobe |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 3 | Table entry to write |
| tbl_dest | input | 8 | Destination value to store |
| tbl_valid | input | 1 | Valid bit to store |
| out_valid | output | 1 | Payload word present |
| out_data | output | 32 | Payload word |
| out_idx | output | 3 | Table index of the packet's destination |
| out_last | output | 1 | Final payload word of the packet |
| hdr_err | output | 1 | One-cycle pulse for a rejected header |

## Verification
The bench feeds the FIFO model with pauses inside packets, from none up to more than 60 cycles. A deframer that counted strobes instead of returned words would lose framing there and misread a payload word as a header. Directed packets cover single-word payloads, lengths of zero and one, unknown and invalidated destinations, and duplicate table entries. A wrong skip count, a missing last flag or a wrong priority shows up as a word or index mismatch on every later packet. The read strobe is also watched against the flags: reading on empty, keeping two reads outstanding near empty, or idling while plenty of data is waiting are each reported.

// File: rtl/deframer_pkg.sv
package deframer_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_PAY  = 2'd1,
    ST_DROP = 2'd2
  } frm_state_t;
endpackage

// File: rtl/rd_pacer.sv
module rd_pacer #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fifo_empty,
  input  logic fifo_almost_empty,
  output logic fifo_rd,
  output logic word_vld
);
  localparam int CW = $clog2(RD_LAT + 1) + 1;

  logic [RD_LAT-1:0] vpipe;
  logic [CW-1:0]     inflight;
  logic              issue;

  assign fifo_rd  = !fifo_empty && (!fifo_almost_empty || inflight == '0);
  assign issue    = fifo_rd && !fifo_empty;
  assign word_vld = vpipe[RD_LAT-1];

  generate
    if (RD_LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= issue;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[RD_LAT-2:0], issue};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(issue) - CW'(word_vld);
  end

  // R2
  rd_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !fifo_rd);
  // R3
  one_inflight_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_almost_empty && $past(fifo_rd)) |-> !fifo_rd);
  // R4
  burst_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_empty && !fifo_almost_empty) |-> fifo_rd);
  // R5
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(RD_LAT));
endmodule

// File: rtl/dest_table.sv
module dest_table #(
  parameter int TBL_N  = 8,
  parameter int DEST_W = 8,
  localparam int IDX_W = $clog2(TBL_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DEST_W-1:0] wr_dest,
  input  logic              wr_valid,
  input  logic [DEST_W-1:0] key,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [DEST_W-1:0] ent_dest [TBL_N];
  logic [TBL_N-1:0]  ent_vld;
  logic [TBL_N-1:0]  match;

  always_ff @(posedge clk) begin
    if (rst) ent_vld <= '0;
    else if (wr_en) ent_vld[wr_addr] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent_dest[wr_addr] <= wr_dest;
  end

  generate
    for (genvar g = 0; g < TBL_N; g++) begin : g_cmp
      assign match[g] = ent_vld[g] && (ent_dest[g] == key);
    end
  endgenerate

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = TBL_N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // R7
  prio_pick_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> match[hit_idx]);
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
  import deframer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 8,
  parameter int IDX_W  = 3,
  localparam int LEN_W = DATA_W - DEST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word,
  output logic [DEST_W-1:0] lk_key,
  input  logic              lk_hit,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [IDX_W-1:0]  out_idx,
  output logic              out_last,
  output logic              hdr_err
);
  frm_state_t        state;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  hdr_len;
  logic [IDX_W-1:0]  cur_idx;
  logic              bad_len;

  assign lk_key  = word[DATA_W-1 -: DEST_W];
  assign hdr_len = word[LEN_W-1:0];
  assign bad_len = hdr_len < LEN_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HDR;
      remain    <= '0;
      cur_idx   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_idx   <= '0;
      out_last  <= 1'b0;
      hdr_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      hdr_err   <= 1'b0;
      if (word_vld) begin
        case (state)
          ST_HDR: begin
            if (bad_len) begin
              hdr_err <= 1'b1;
            end else if (!lk_hit) begin
              hdr_err <= 1'b1;
              remain  <= hdr_len - LEN_W'(1);
              state   <= ST_DROP;
            end else begin
              remain  <= hdr_len - LEN_W'(1);
              cur_idx <= lk_idx;
              state   <= ST_PAY;
            end
          end
          ST_PAY: begin
            out_valid <= 1'b1;
            out_data  <= word;
            out_idx   <= cur_idx;
            out_last  <= (remain == LEN_W'(1));
            remain    <= remain - LEN_W'(1);
            if (remain == LEN_W'(1)) state <= ST_HDR;
          end
          ST_DROP: begin
            remain <= remain - LEN_W'(1);
            if (remain == LEN_W'(1)) state <= ST_HDR;
          end
          default: state <= ST_HDR;
        endcase
      end
    end
  end

  // R5
  out_from_word_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(word_vld));
  // R8
  err_from_word_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_err |-> ($past(word_vld) && !out_valid));
  // R6
  last_in_pay_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R9
  no_pay_remain_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_HDR) |-> (remain != '0));
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer #(
  parameter int DATA_W = 32,
  parameter int DEST_W = 8,
  parameter int TBL_N  = 8,
  parameter int RD_LAT = 2,
  localparam int IDX_W = $clog2(TBL_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_empty,
  input  logic              fifo_almost_empty,
  output logic              fifo_rd,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [DEST_W-1:0] tbl_dest,
  input  logic              tbl_valid,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [IDX_W-1:0]  out_idx,
  output logic              out_last,
  output logic              hdr_err
);
  logic              word_vld;
  logic [DEST_W-1:0] lk_key;
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx;

  rd_pacer #(.RD_LAT(RD_LAT)) pacer_i (
    .clk(clk), .rst(rst),
    .fifo_empty(fifo_empty), .fifo_almost_empty(fifo_almost_empty),
    .fifo_rd(fifo_rd), .word_vld(word_vld)
  );

  dest_table #(.TBL_N(TBL_N), .DEST_W(DEST_W)) table_i (
    .clk(clk), .rst(rst),
    .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_dest(tbl_dest), .wr_valid(tbl_valid),
    .key(lk_key), .hit(lk_hit), .hit_idx(lk_idx)
  );

  frame_fsm #(.DATA_W(DATA_W), .DEST_W(DEST_W), .IDX_W(IDX_W)) fsm_i (
    .clk(clk), .rst(rst),
    .word_vld(word_vld), .word(fifo_data),
    .lk_key(lk_key), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .out_valid(out_valid), .out_data(out_data), .out_idx(out_idx),
    .out_last(out_last), .hdr_err(hdr_err)
  );

  // R1
  idle_after_rst_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !hdr_err && !out_last));
endmodule

// File: tb/pkt_deframer_tb_top.sv
module pkt_deframer_tb_top;
  localparam int CLK_P  = 10;
  localparam int RD_LAT = 2;
  localparam int AE_TH  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_empty = 1'b1;
  logic        fifo_almost_empty = 1'b1;
  logic        fifo_rd;
  logic [31:0] fifo_data;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_addr = '0;
  logic [7:0]  tbl_dest = '0;
  logic        tbl_valid = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [2:0]  out_idx;
  logic        out_last;
  logic        hdr_err;

  always #(CLK_P/2) clk = ~clk;

  pkt_deframer #(.RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rst(rst),
    .fifo_empty(fifo_empty), .fifo_almost_empty(fifo_almost_empty),
    .fifo_rd(fifo_rd), .fifo_data(fifo_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_dest(tbl_dest), .tbl_valid(tbl_valid),
    .out_valid(out_valid), .out_data(out_data), .out_idx(out_idx),
    .out_last(out_last), .hdr_err(hdr_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FIFO deframer FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // FIFO model: registered flags, data RD_LAT cycles after strobe
  logic [31:0] fq[$];
  logic [31:0] dpipe [RD_LAT];
  assign fifo_data = dpipe[RD_LAT-1];

  always @(posedge clk) begin
    logic [31:0] w;
    int n;
    w = 32'hDEAD_BEEF;
    if (fifo_rd && fq.size() > 0) w = fq.pop_front();
    n = fq.size();
    fifo_empty        <= (n == 0);
    fifo_almost_empty <= (n <= AE_TH);
    dpipe[0] <= w;
    for (int i = 1; i < RD_LAT; i++) dpipe[i] <= dpipe[i-1];
  end

  // Bench model of the table and the expected output stream
  logic [7:0] m_dest [8];
  bit         m_vld  [8];
  logic [31:0] e_data[$];
  int          e_idx[$];
  bit          e_last[$];
  int          err_exp = 0;
  int          err_seen = 0;

  function automatic int lookup(input logic [7:0] d);
    for (int i = 0; i < 8; i++) if (m_vld[i] && m_dest[i] == d) return i;
    return -1;
  endfunction

  task automatic tbl_write(input int a, input logic [7:0] d, input bit v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 3'(a); tbl_dest = d; tbl_valid = v;
    @(negedge clk);
    tbl_we = 1'b0;
    m_dest[a] = d; m_vld[a] = v;
  endtask

  task automatic push_word(input logic [31:0] w, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    fq.push_back(w);
  endtask

  // gap_mode: 0 none, 1 short random, 2 long random, 3 one 60-cycle pause mid packet
  task automatic send_pkt(input logic [7:0] d, input int len, input int gap_mode);
    int ix;
    logic [31:0] w;
    int g;
    push_word({d, 24'(len)}, 0);
    ix = lookup(d);
    if (len < 2) begin
      err_exp++;
      return;
    end
    if (ix < 0) err_exp++;
    for (int i = 1; i < len; i++) begin
      w = $urandom;
      g = 0;
      if (gap_mode == 1) g = ($urandom % 4 == 0) ? $urandom % 4 : 0;
      if (gap_mode == 2) g = ($urandom % 8 == 0) ? 20 + $urandom % 60 : 0;
      if (gap_mode == 3 && i == len / 2) g = 60;
      push_word(w, g);
      if (ix >= 0) begin
        e_data.push_back(w); e_idx.push_back(ix); e_last.push_back(i == len - 1);
      end
    end
  endtask

  task automatic drain();
    int k;
    k = 0;
    while ((fq.size() > 0 || k < 10) && !done) begin
      @(negedge clk);
      if (fq.size() > 0) k = 0; else k++;
    end
  endtask

  // Output monitor: R5, R6, R7
  logic [31:0] xd;
  int          xi;
  bit          xl;
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (e_data.size() == 0) begin
        check(0, "R8 unexpected output word", out_data, 0);
      end else begin
        xd = e_data.pop_front(); xi = e_idx.pop_front(); xl = e_last.pop_front();
        check(out_data == xd, "R5 payload word", out_data, xd);
        check(int'(out_idx) == xi, "R6/R7 destination index", out_idx, xi);
        check(out_last == xl, "R6 last flag", out_last, xl);
      end
    end
    if (!rst && hdr_err) err_seen++;
  end

  // Strobe monitor: R2, R3, R4
  int v_r2 = 0, v_r3 = 0, v_r4 = 0;
  bit rd_hist [RD_LAT];
  always @(negedge clk) begin
    bit recent;
    if (!rst) begin
      recent = 0;
      for (int i = 0; i < RD_LAT - 1; i++) recent |= rd_hist[i];
      if (fifo_empty && fifo_rd) v_r2++;
      if (fifo_almost_empty && recent && fifo_rd) v_r3++;
      if (!fifo_empty && !fifo_almost_empty && !fifo_rd) v_r4++;
    end
    for (int i = RD_LAT - 1; i > 0; i--) rd_hist[i] = rd_hist[i-1];
    rd_hist[0] = !rst && fifo_rd;
  end

  task automatic final_report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(0, "watchdog expired", 0, 1);
      final_report();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) begin m_vld[i] = 0; m_dest[i] = '0; end
    for (int i = 0; i < RD_LAT; i++) begin dpipe[i] = '0; rd_hist[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!fifo_rd, "R1 fifo_rd after reset", fifo_rd, 0);
    check(!out_valid && !out_last, "R1 out_valid after reset", out_valid, 0);
    check(!hdr_err, "R1 hdr_err after reset", hdr_err, 0);

    // R10 table load: entries 0..5, duplicate at 6, invalid entry 7
    for (int i = 0; i < 6; i++) tbl_write(i, 8'h10 + 8'(i), 1);
    tbl_write(6, 8'h12, 1);
    tbl_write(7, 8'h77, 0);

    // Directed corner cases
    send_pkt(8'h11, 2, 0);   // R6 single payload word, last on first
    send_pkt(8'h77, 4, 0);   // R10 invalid entry, R8 drop 3
    send_pkt(8'h10, 0, 0);   // R9 length zero
    send_pkt(8'h10, 1, 0);   // R9 length one
    send_pkt(8'h12, 5, 0);   // R7 lowest index wins
    send_pkt(8'h99, 3, 0);   // R8 unknown destination
    send_pkt(8'h13, 30, 3);  // R5 60-cycle pause mid packet
    drain();
    check(e_data.size() == 0, "R5 directed words all delivered", e_data.size(), 0);
    check(err_seen == err_exp, "R8/R9 directed error count", err_seen, err_exp);

    // Constrained random traffic
    for (int p = 0; p < 60; p++) begin
      int len, sel, gm;
      logic [7:0] d;
      sel = $urandom % 10;
      d = (sel < 8) ? 8'h10 + 8'($urandom % 6) : ((sel == 8) ? 8'h77 : 8'hA0 + 8'($urandom % 16));
      len = ($urandom % 12 == 0) ? $urandom % 2 : 2 + $urandom % 24;
      gm = ($urandom % 5 == 0) ? 2 : (($urandom % 2) ? 1 : 0);
      send_pkt(d, len, gm);
    end
    drain();
    check(e_data.size() == 0, "R5 random words all delivered", e_data.size(), 0);
    check(err_seen == err_exp, "R8 random error count", err_seen, err_exp);

    // R10 clearing a valid bit makes the destination unknown
    tbl_write(1, 8'h11, 0);
    send_pkt(8'h11, 4, 0);
    send_pkt(8'h14, 3, 0);
    drain();
    check(e_data.size() == 0, "R10 words after invalidation", e_data.size(), 0);
    check(err_seen == err_exp, "R10 invalidated entry raises error", err_seen, err_exp);

    check(v_r2 == 0, "R2 strobe while empty", v_r2, 0);
    check(v_r3 == 0, "R3 second read in flight near empty", v_r3, 0);
    check(v_r4 == 0, "R4 idle strobe with data waiting", v_r4, 0);

    done = 1;
    final_report();
  end
endmodule